// File: doc/BRIEF.md
# Eight-Operation Signed ALU

This block is a purely combinational arithmetic-logic unit. It takes two 8-bit operands and a 3-bit operation select, and returns an 8-bit result with three status bits. The arithmetic operations read both operands as two's complement signed numbers and return the low 8 bits of the exact answer. The logic operations work bit by bit on the raw vectors.

The arithmetic set covers the usual sum and difference. It also has a reversed difference (second operand minus first) and arithmetic negation of either operand. The logic set covers AND, OR and inversion of the first operand. One shared adder does every arithmetic operation. A small decoder turns the select code into operand-conditioning strobes for that adder. An overflow bit reports when a signed result cannot be represented in 8 bits. Zero and negative bits describe whatever result appears.

Top module: `sop_alu`

## Requirements
- R1: Both operands are 8-bit two's complement values. The arithmetic result is the exact signed outcome reduced modulo 256, so 127 + 1 gives 8'h80.
- R2: Select 3'b000 gives opA + opB, and select 3'b001 gives opA - opB.
- R3: Select 3'b010 gives -opA, and select 3'b011 gives -opB.
- R4: Select 3'b100 gives opB - opA.
- R5: Select 3'b101 gives opA & opB, and select 3'b110 gives opA | opB.
- R6: Select 3'b111 gives ~opA, and opB has no effect on it.
- R7: For selects 000, 001 and 100, overflow is 1 exactly when the true signed result lies outside -128..127.
- R8: For selects 010 and 011, overflow is 1 exactly when the negated operand is -128 (8'h80). In that case the result is 8'h80.
- R9: For selects 101, 110 and 111, overflow is 0.
- R10: zero is 1 exactly when all 8 result bits are 0, whatever the operation.
- R11: negative equals result bit 7, whatever the operation.
- R12: The block holds no state. Every output is a function of the present inputs only, and is defined for every select value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | 8 | First operand (two's complement for arithmetic) |
| opB | input | 8 | Second operand (two's complement for arithmetic) |
| opSel | input | 3 | Operation select code |
| result | output | 8 | Low 8 bits of the selected operation |
| overflow | output | 1 | Signed overflow of the arithmetic operations |
| zero | output | 1 | High when result is all zeros |
| negative | output | 1 | Copy of result bit 7 |

## Verification
Every output is due in the same cycle as its inputs, with no register between them. The bench changes operands and select on a clock edge and samples all four outputs one nanosecond later, at mid-phase, before the next change. The sweep runs all eight select codes. Each code is paired with every first-operand value and a 96-value second-operand set. That set covers both ends of the signed range and the zero/minus-one crossing. Expected results and flags come from integer arithmetic in the bench.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [2:0] {
    OP_ADD  = 3'b000,
    OP_SUB  = 3'b001,
    OP_NEGA = 3'b010,
    OP_NEGB = 3'b011,
    OP_RSUB = 3'b100,
    OP_AND  = 3'b101,
    OP_OR   = 3'b110,
    OP_NOTA = 3'b111
  } aluOp_e;

  // How an operand is conditioned before it reaches the shared adder.
  typedef enum logic [1:0] {
    SRC_PASS = 2'd0,
    SRC_INV  = 2'd1,
    SRC_ZERO = 2'd2
  } srcSel_e;

  typedef enum logic [1:0] {
    LOG_AND = 2'd0,
    LOG_OR  = 2'd1,
    LOG_NOT = 2'd2
  } logicSel_e;

  // Strobes sent from the decoder to the datapath.
  typedef struct packed {
    srcSel_e   xSel;
    srcSel_e   ySel;
    logic      carryIn;
    logic      useLogic;
    logicSel_e logicSel;
  } aluStrobes_t;

endpackage

// File: rtl/alu_ctrl.sv
module alu_ctrl
  import alu_pkg::*;
(
  input  logic [2:0]  opSel,
  output aluStrobes_t strobes
);

  always_comb begin
    strobes          = '0;
    strobes.xSel     = SRC_PASS;
    strobes.ySel     = SRC_PASS;
    strobes.logicSel = LOG_AND;
    unique case (aluOp_e'(opSel))
      OP_ADD: ;
      OP_SUB: begin
        strobes.ySel    = SRC_INV;
        strobes.carryIn = 1'b1;
      end
      OP_NEGA: begin
        strobes.xSel    = SRC_INV;
        strobes.ySel    = SRC_ZERO;
        strobes.carryIn = 1'b1;
      end
      OP_NEGB: begin
        strobes.xSel    = SRC_ZERO;
        strobes.ySel    = SRC_INV;
        strobes.carryIn = 1'b1;
      end
      OP_RSUB: begin
        strobes.xSel    = SRC_INV;
        strobes.carryIn = 1'b1;
      end
      OP_AND: strobes.useLogic = 1'b1;
      OP_OR: begin
        strobes.useLogic = 1'b1;
        strobes.logicSel = LOG_OR;
      end
      OP_NOTA: begin
        strobes.useLogic = 1'b1;
        strobes.logicSel = LOG_NOT;
      end
      default: ;
    endcase
  end

  // R12: logic ops never ask the adder for a carry.
  always_comb begin
    if (!$isunknown(opSel))
      p_logic_no_carry_r12: assert (!(strobes.useLogic && strobes.carryIn))
        else $error("logic op with carry strobe");
  end

endmodule

// File: rtl/alu_src_cond.sv
module alu_src_cond
  import alu_pkg::*;
#(
  parameter int DataWidth = 8
) (
  input  logic [DataWidth-1:0] din,
  input  srcSel_e              sel,
  output logic [DataWidth-1:0] dout
);

  always_comb begin
    unique case (sel)
      SRC_PASS: dout = din;
      SRC_INV:  dout = ~din;
      default:  dout = '0;
    endcase
  end

endmodule

// File: rtl/alu_flags.sv
module alu_flags #(
  parameter int DataWidth = 8
) (
  input  logic [DataWidth-1:0] value,
  output logic                 zero,
  output logic                 negative
);

  localparam int SignBit = DataWidth - 1;

  assign zero     = ~|value;
  assign negative = value[SignBit];

  // R10/R11: a zero value can never be negative.
  always_comb begin
    if (!$isunknown(value))
      p_zero_not_neg_r10: assert (!(zero && negative))
        else $error("zero and negative together");
  end

endmodule

// File: rtl/alu_datapath.sv
module alu_datapath
  import alu_pkg::*;
#(
  parameter int DataWidth = 8
) (
  input  logic [DataWidth-1:0] opA,
  input  logic [DataWidth-1:0] opB,
  input  aluStrobes_t          strobes,
  output logic [DataWidth-1:0] result,
  output logic                 overflow,
  output logic                 zero,
  output logic                 negative
);

  localparam int SignBit = DataWidth - 1;

  logic [DataWidth-1:0] adderX;
  logic [DataWidth-1:0] adderY;
  logic [DataWidth-1:0] sum;
  logic [DataWidth-1:0] logicRes;
  logic                 addOvf;

  alu_src_cond #(.DataWidth(DataWidth)) u_condX (
    .din (opA),
    .sel (strobes.xSel),
    .dout(adderX)
  );

  alu_src_cond #(.DataWidth(DataWidth)) u_condY (
    .din (opB),
    .sel (strobes.ySel),
    .dout(adderY)
  );

  // One shared adder: x + y + carryIn covers every arithmetic op.
  assign sum = adderX + adderY + {{(DataWidth-1){1'b0}}, strobes.carryIn};

  // Signed overflow: equal input signs, differing result sign.
  assign addOvf = (adderX[SignBit] == adderY[SignBit]) && (sum[SignBit] != adderX[SignBit]);

  always_comb begin
    unique case (strobes.logicSel)
      LOG_AND: logicRes = opA & opB;
      LOG_OR:  logicRes = opA | opB;
      default: logicRes = ~opA;
    endcase
  end

  assign result   = strobes.useLogic ? logicRes : sum;
  assign overflow = !strobes.useLogic && addOvf;

  alu_flags #(.DataWidth(DataWidth)) u_flags (
    .value   (result),
    .zero    (zero),
    .negative(negative)
  );

endmodule

// File: rtl/sop_alu.sv
module sop_alu
  import alu_pkg::*;
#(
  parameter int DataWidth = 8
) (
  input  logic [DataWidth-1:0] opA,
  input  logic [DataWidth-1:0] opB,
  input  logic [2:0]           opSel,
  output logic [DataWidth-1:0] result,
  output logic                 overflow,
  output logic                 zero,
  output logic                 negative
);

  localparam logic [DataWidth-1:0] MinVal = {1'b1, {(DataWidth-1){1'b0}}};

  aluStrobes_t strobes;

  alu_ctrl u_ctrl (
    .opSel  (opSel),
    .strobes(strobes)
  );

  alu_datapath #(.DataWidth(DataWidth)) u_dp (
    .opA     (opA),
    .opB     (opB),
    .strobes (strobes),
    .result  (result),
    .overflow(overflow),
    .zero    (zero),
    .negative(negative)
  );

  always_comb begin
    if (!$isunknown({opA, opB, opSel})) begin
      if (opSel == 3'b000)
        p_add_r2: assert (result == DataWidth'(opA + opB)) else $error("add mismatch");
      if (opSel == 3'b001)
        p_sub_r2: assert (result == DataWidth'(opA - opB)) else $error("sub mismatch");
      if (opSel == 3'b010)
        p_nega_r3: assert (result == DataWidth'(-opA)) else $error("negate a mismatch");
      if (opSel == 3'b011)
        p_negb_r3: assert (result == DataWidth'(-opB)) else $error("negate b mismatch");
      if (opSel == 3'b100)
        p_rsub_r4: assert (result == DataWidth'(opB - opA)) else $error("reverse sub mismatch");
      if (opSel == 3'b101)
        p_and_r5: assert (result == (opA & opB)) else $error("and mismatch");
      if (opSel == 3'b111)
        p_not_r6: assert (result == ~opA) else $error("not mismatch");
      if (opSel == 3'b010)
        p_neg_ovf_r8: assert (overflow == (opA == MinVal)) else $error("negate overflow wrong");
      if (opSel[2] && opSel != 3'b100)
        p_no_overflow_r9: assert (!overflow) else $error("logic op overflow");
      p_sign_r11: assert (negative == result[DataWidth-1]) else $error("negative flag wrong");
    end
  end

endmodule

// File: tb/sim_sop_alu.sv
module sim_sop_alu;

  logic       clk = 1'b0;
  logic [7:0] opA = '0;
  logic [7:0] opB = '0;
  logic [2:0] opSel = '0;
  logic [7:0] result;
  logic       overflow, zero, negative;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  sop_alu u0 (
    .opA(opA), .opB(opB), .opSel(opSel),
    .result(result), .overflow(overflow), .zero(zero), .negative(negative)
  );

  always #2 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 180000 && !done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run hung, actual cycles %0d expected under 180000", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Drives one vector at a clock edge, samples 1 ns later at mid-phase.
  task automatic runVec(logic [2:0] op, logic [7:0] a, logic [7:0] b, string extraTag);
    int sa = int'($signed(a));
    int sb = int'($signed(b));
    int exact = 0;
    logic [7:0] expRes;
    logic expOvf = 1'b0;
    string resTag, ovfTag;
    bit arith = 1'b1;
    case (op)
      3'b000: begin exact = sa + sb; resTag = "R2"; ovfTag = "R7"; end
      3'b001: begin exact = sa - sb; resTag = "R2"; ovfTag = "R7"; end
      3'b010: begin exact = -sa;     resTag = "R3"; ovfTag = "R8"; end
      3'b011: begin exact = -sb;     resTag = "R3"; ovfTag = "R8"; end
      3'b100: begin exact = sb - sa; resTag = "R4"; ovfTag = "R7"; end
      3'b101: begin arith = 0; expRes = a & b; resTag = "R5"; ovfTag = "R9"; end
      3'b110: begin arith = 0; expRes = a | b; resTag = "R5"; ovfTag = "R9"; end
      default: begin arith = 0; expRes = ~a;   resTag = "R6"; ovfTag = "R9"; end
    endcase
    if (arith) begin
      expRes = exact[7:0];
      expOvf = (exact < -128) || (exact > 127);
    end
    opA = a; opB = b; opSel = op;
    #1;
    if (extraTag != "") chk(extraTag, "result", int'(result), int'(expRes));
    chk(resTag, "result", int'(result), int'(expRes));
    chk(ovfTag, "overflow", int'(overflow), int'(expOvf));
    chk("R10", "zero", int'(zero), int'(expRes == 8'h00));
    chk("R11", "negative", int'(negative), int'(expRes[7]));
    #1;
  endtask

  initial begin
    // R12: outputs defined with no reset, straight from the inputs (0 + 0).
    #1;
    chk("R12", "initial result", int'(result), 0);
    chk("R12", "initial zero", int'(zero), 1);
    chk("R12", "initial overflow", int'(overflow), 0);
    #1;

    // Directed corners.
    runVec(3'b000, 8'h7F, 8'h01, "R1");   // wraps to 0x80, overflow
    runVec(3'b001, 8'h80, 8'h01, "R1");   // wraps to 0x7F, overflow
    runVec(3'b000, 8'hFF, 8'h01, "R1");   // -1 + 1 = 0
    runVec(3'b010, 8'h80, 8'h00, "R8");   // -(-128) overflows
    runVec(3'b011, 8'h00, 8'h80, "R8");
    runVec(3'b100, 8'h7F, 8'h80, "R4");   // -128 - 127 overflows
    runVec(3'b111, 8'h5A, 8'hFF, "R6");   // opB ignored
    runVec(3'b111, 8'h5A, 8'h00, "R6");

    // Near-exhaustive sweep: all ops, all opA, 96 opB values.
    for (int op = 0; op < 8; op++)
      for (int a = 0; a < 256; a++)
        for (int j = 0; j < 96; j++) begin
          int b = (j < 32) ? j : ((j < 64) ? j + 80 : j + 160);
          runVec(3'(op), 8'(a), 8'(b), "");
        end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule